// File: doc/BRIEF.md
# Reloading Interval Timer with Acknowledge

This block raises an interrupt request after a programmed number of CPU-cycle ticks or scanline-length periods. Software loads an 8-bit reload value as two 4-bit halves and starts the timer with a control write. The 8-bit counter counts up from the reload value. When it passes 0xFF it reloads itself and sets a pending flag, and that flag drives the interrupt line. In cycle mode the counter advances on every tick. In scanline mode a prescaler advances it once every 114, 114 and 113 ticks in turn, which approximates 341/3 CPU cycles per line.

The acknowledge write behaves differently from a plain stop. It copies the saved auto-repeat bit into the run enable. The timer therefore keeps running after an acknowledge only when auto-repeat was requested. Every register write, of any kind, drops a pending interrupt.

The controller is a three-state machine:

- ST_STOPPED: the counter and prescaler are frozen.
- ST_COUNT_CYCLE: the counter steps on every tick.
- ST_COUNT_LINE: the counter steps on every prescaler period.

The state changes only on a write, through these transitions:

- START: a control write with run bit 1 enters ST_COUNT_CYCLE or ST_COUNT_LINE, chosen by the mode bit.
- HALT: a control write with run bit 0 enters ST_STOPPED.
- REARM: an acknowledge with the repeat bit set enters the counting state that matches the stored mode.
- DISARM: an acknowledge with the repeat bit clear enters ST_STOPPED.

Top module: `irq_reload_timer`

## Requirements
- R1: After reset the reload value, counter, prescaler, repeat bit and pending flag are zero, the state is ST_STOPPED and irq is low. Ticks have no effect until a control write.
- R2: A write with wr_sel = 0 stores wr_data into reload bits 3:0. A write with wr_sel = 1 stores wr_data into reload bits 7:4. The other half is left as it was.
- R3: A write with wr_sel = 2 (control) takes bit 0 as the repeat bit, bit 1 as the run bit and bit 2 as the mode (1 = cycle mode, 0 = scanline mode). When bit 1 is set, the counter is loaded with the reload value and the prescaler is cleared to the start of its 114-tick phase.
- R4: In cycle mode with reload value L, irq rises on the clock edge that samples the (256 - L)-th tick after the loading control write. It does not rise before that edge.
- R5: On overflow the counter reloads from the reload value and keeps counting. Another full period of 256 - L steps passes before the next overflow.
- R6: In scanline mode one counter step takes 114, 114 and 113 ticks in a repeating order, starting with 114 after a load.
- R7: Every write, whatever wr_sel is, clears the pending flag, so irq is low after that edge.
- R8: A write with wr_sel = 3 (acknowledge) sets both the run bit and the repeat bit to the old repeat bit. The counter value and the stored mode are kept.
- R9: A control write with bit 1 clear stops the timer without loading the counter. The counter holds its value through later ticks and resumes from that value after a rearming acknowledge.
- R10: In a clock cycle where wr_en is high, the counter and prescaler do not advance, even if cpu_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 reload low, 1 reload high, 2 control, 3 acknowledge |
| wr_data | input | 4 | Write data nibble |
| cpu_tick | input | 1 | One-cycle pulse per CPU cycle |
| irq | output | 1 | Interrupt request, high while an overflow is pending |

## Verification
A wrong internal state shows up only as a changed time of the irq rising edge. It cannot be read out directly.

- A bad reload nibble or a miscounted counter moves the first rise by at least one tick.
- A prescaler with the wrong phase lengths moves the rise by one tick from the second or third scanline step onward.
- A wrong repeat or mode value after an acknowledge shows as a missing or early second interrupt.

For these reasons the bench measures the exact tick on which irq rises, checking both the tick before it and the rising tick itself.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED     = 2'd0,
        ST_COUNT_CYCLE = 2'd1,
        ST_COUNT_LINE  = 2'd2
    } tmr_state_e;

    localparam logic [1:0] SEL_RELOAD_LO = 2'd0;
    localparam logic [1:0] SEL_RELOAD_HI = 2'd1;
    localparam logic [1:0] SEL_CONTROL   = 2'd2;
    localparam logic [1:0] SEL_ACK       = 2'd3;

    localparam int CTL_REPEAT_BIT = 0;
    localparam int CTL_RUN_BIT    = 1;
    localparam int CTL_MODE_BIT   = 2;

endpackage

// File: rtl/irq_tmr_reload.sv
module irq_tmr_reload #(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [NIB_W-1:0]     din,
    output logic [2*NIB_W-1:0]   reload
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else begin
            if (wr_lo) reload[NIB_W-1:0]       <= din;
            if (wr_hi) reload[2*NIB_W-1:NIB_W] <= din;
        end
    end

endmodule

// File: rtl/irq_tmr_prescale.sv
module irq_tmr_prescale #(
    parameter int LINE_LONG   = 114,
    parameter int LINE_SHORT  = 113,
    parameter int LINE_PHASES = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            adv,
    output logic                            step,
    output logic [$clog2(LINE_LONG)-1:0]    pre_cnt
);

    localparam int PRE_W = $clog2(LINE_LONG);
    localparam int PH_W  = (LINE_PHASES > 1) ? $clog2(LINE_PHASES) : 1;
    localparam logic [PRE_W-1:0] LONG_LAST  = PRE_W'(LINE_LONG - 1);
    localparam logic [PRE_W-1:0] SHORT_LAST = PRE_W'(LINE_SHORT - 1);
    localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(LINE_PHASES - 1);

    logic [PH_W-1:0]  phase;
    logic [PRE_W-1:0] last;

    assign last = (phase == PH_LAST) ? SHORT_LAST : LONG_LAST;
    assign step = adv && (pre_cnt == last);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_cnt <= '0;
            phase   <= '0;
        end else if (adv) begin
            if (pre_cnt == last) begin
                pre_cnt <= '0;
                phase   <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_tmr_counter.sv
module irq_tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign ovf = step && !load && (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= (count == CNT_MAX) ? load_val : count + 1'b1;
        end
    end

endmodule

// File: rtl/irq_reload_timer.sv
module irq_reload_timer
    import irq_tmr_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int LINE_LONG   = 114,
    parameter int LINE_SHORT  = 113,
    parameter int LINE_PHASES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              cpu_tick,
    output logic              irq
);

    localparam int CNT_W = 2 * NIB_W;
    localparam int PRE_W = $clog2(LINE_LONG);

    tmr_state_e          state_q, state_d;
    logic                repeat_q, repeat_d;
    logic                mode_q, mode_d;
    logic                pend_q;
    logic [CNT_W-1:0]    reload;
    logic [CNT_W-1:0]    count;
    logic [PRE_W-1:0]    pre_cnt;
    logic                wr_ctl, wr_ack, load;
    logic                adv_any, pre_step, cnt_step, ovf;

    assign wr_ctl  = wr_en && (wr_sel == SEL_CONTROL);
    assign wr_ack  = wr_en && (wr_sel == SEL_ACK);
    assign load    = wr_ctl && wr_data[CTL_RUN_BIT];
    assign adv_any = cpu_tick && !wr_en;

    irq_tmr_reload #(.NIB_W(NIB_W)) u_reload (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_en && (wr_sel == SEL_RELOAD_LO)),
        .wr_hi  (wr_en && (wr_sel == SEL_RELOAD_HI)),
        .din    (wr_data),
        .reload (reload)
    );

    irq_tmr_prescale #(
        .LINE_LONG   (LINE_LONG),
        .LINE_SHORT  (LINE_SHORT),
        .LINE_PHASES (LINE_PHASES)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .adv     (adv_any && (state_q == ST_COUNT_LINE)),
        .step    (pre_step),
        .pre_cnt (pre_cnt)
    );

    always_comb begin
        unique case (state_q)
            ST_COUNT_CYCLE: cnt_step = adv_any;
            ST_COUNT_LINE:  cnt_step = pre_step;
            default:        cnt_step = 1'b0;
        endcase
    end

    irq_tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (cnt_step),
        .load_val (reload),
        .count    (count),
        .ovf      (ovf)
    );

    // next-state logic: START / HALT on control, REARM / DISARM on acknowledge
    always_comb begin
        state_d  = state_q;
        repeat_d = repeat_q;
        mode_d   = mode_q;
        if (wr_ctl) begin
            repeat_d = wr_data[CTL_REPEAT_BIT];
            mode_d   = wr_data[CTL_MODE_BIT];
            if (wr_data[CTL_RUN_BIT])
                state_d = wr_data[CTL_MODE_BIT] ? ST_COUNT_CYCLE : ST_COUNT_LINE;
            else
                state_d = ST_STOPPED;
        end else if (wr_ack) begin
            unique case (repeat_q)
                1'b1:    state_d = mode_q ? ST_COUNT_CYCLE : ST_COUNT_LINE;
                default: state_d = ST_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_STOPPED;
            repeat_q <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            repeat_q <= repeat_d;
            mode_q   <= mode_d;
        end
    end

    // output process: pending flag
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (wr_en) pend_q <= 1'b0;
        else if (ovf)   pend_q <= 1'b1;
    end

    assign irq = pend_q;

endmodule

// File: rtl/irq_reload_timer_chk.sv
module irq_reload_timer_chk
    import irq_tmr_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PRE_W     = 7,
    parameter int LINE_LONG = 114
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [3:0]       wr_data,
    input  logic             cpu_tick,
    input  logic             irq,
    input  tmr_state_e       state_q,
    input  logic [CNT_W-1:0] count,
    input  logic [PRE_W-1:0] pre_cnt
);

    AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq); // R7

    AST_IRQ_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cpu_tick) && !$past(wr_en)); // R4

    AST_STATE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q)); // R3

    AST_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |=> !$rose(irq)); // R8

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !wr_en) |=> $stable(count)); // R9

    AST_NO_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_sel == SEL_CONTROL && wr_data[1])) |=> $stable(count) && $stable(pre_cnt)); // R10

    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt < PRE_W'(LINE_LONG)); // R6

endmodule

bind irq_reload_timer irq_reload_timer_chk #(
    .CNT_W     (CNT_W),
    .PRE_W     (PRE_W),
    .LINE_LONG (LINE_LONG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cpu_tick (cpu_tick),
    .irq      (irq),
    .state_q  (state_q),
    .count    (count),
    .pre_cnt  (pre_cnt)
);

// File: tb/irq_reload_timer_test.sv
`timescale 1ns/1ps
module irq_reload_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [3:0] wr_data = 4'd0;
    logic       cpu_tick = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq)
    );

    // {reload[7:0], cycle_mode, ticks to irq[10:0]}
    localparam int NVEC = 9;
    localparam logic [19:0] VEC [NVEC] = '{
        {8'hF0, 1'b1, 11'd16},
        {8'hFF, 1'b1, 11'd1},
        {8'h80, 1'b1, 11'd128},
        {8'h00, 1'b1, 11'd256},
        {8'hFF, 1'b0, 11'd114},
        {8'hFE, 1'b0, 11'd228},
        {8'hFD, 1'b0, 11'd341},
        {8'hFC, 1'b0, 11'd455},
        {8'hFB, 1'b0, 11'd569}
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cpu_tick = 1'b1;
            @(negedge clk); cpu_tick = 1'b0;
        end
    endtask

    task automatic set_reload(input logic [7:0] v);
        wr(2'd0, v[3:0]);
        wr(2'd1, v[7:4]);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq, 1'b0, "R1 reset irq");
        ticks(300);
        check(irq, 1'b0, "R1 stopped after reset");

        // vector table: R2 R3 R4 R6
        for (int v = 0; v < NVEC; v++) begin
            set_reload(VEC[v][19:12]);
            wr(2'd2, {1'b0, VEC[v][11], 2'b10});
            if (VEC[v][10:0] > 1) ticks(int'(VEC[v][10:0]) - 1);
            check(irq, 1'b0, VEC[v][11] ? "R4 before overflow" : "R6 before overflow");
            ticks(1);
            check(irq, 1'b1, VEC[v][11] ? "R4 overflow tick" : "R6 overflow tick");
            wr(2'd2, 4'b0000);
            check(irq, 1'b0, "R7 control write clears irq");
        end

        // R2 only-half update: low then high half separately
        set_reload(8'h00);
        wr(2'd1, 4'hF);
        wr(2'd2, 4'b0110);
        ticks(15);
        check(irq, 1'b0, "R2 high half only");
        ticks(1);
        check(irq, 1'b1, "R2 high half only overflow");
        wr(2'd0, 4'h8);
        check(irq, 1'b0, "R7 reload write clears irq");
        // counter reloaded with 0xF0 at overflow; one tick already lost? no: 16 steps per period
        ticks(15);
        check(irq, 1'b0, "R5 second period early");
        ticks(1);
        check(irq, 1'b1, "R5 second period end");

        // R8 acknowledge with repeat set keeps running
        set_reload(8'hF0);
        wr(2'd2, 4'b0111);
        ticks(16);
        check(irq, 1'b1, "R8 first irq");
        wr(2'd3, 4'b0000);
        check(irq, 1'b0, "R8 ack clears irq");
        ticks(15);
        check(irq, 1'b0, "R8 rearmed early");
        ticks(1);
        check(irq, 1'b1, "R8 rearmed irq");

        // R8 acknowledge without repeat stops
        wr(2'd2, 4'b0110);
        ticks(16);
        check(irq, 1'b1, "R8 no-repeat irq");
        wr(2'd3, 4'b0000);
        ticks(300);
        check(irq, 1'b0, "R8 disarmed stays low");

        // R9 halt holds counter, ack resumes
        wr(2'd2, 4'b0110);
        ticks(5);
        wr(2'd2, 4'b0101);
        ticks(50);
        check(irq, 1'b0, "R9 halted no irq");
        wr(2'd3, 4'b0000);
        ticks(10);
        check(irq, 1'b0, "R9 resumed early");
        ticks(1);
        check(irq, 1'b1, "R9 resumed from held count");

        // R10 write coinciding with a tick does not advance
        wr(2'd2, 4'b0110);
        ticks(5);
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 4'h0; cpu_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; cpu_tick = 1'b0;
        ticks(10);
        check(irq, 1'b0, "R10 write-cycle tick ignored");
        ticks(1);
        check(irq, 1'b1, "R10 irq one tick later");

        done = 1'b1;
        finish_run();
    end

endmodule